// File: doc/BRIEF.md
# Debug Halt and Trace Control Unit

This unit sits between a small debug monitor processor and the CPU that the monitor watches. It holds an 8-bit control register, which the monitor writes, and an 8-bit status byte, which can only be read. Three raw match pulses arrive from comparators outside the block: an instruction address breakpoint, a data watchpoint and a flag match. Each pulse can stop the target only when its own enable bit in the control register is set. The unit registers the combined result as a single halt request. It also records which sources caused a halt, and these records stay set until the monitor next writes the control register.

The same control register drives a history capture engine. Each capture event from the target produces a write enable and an entry index for an external history buffer. In one-shot mode the engine writes the last entry, then stops and clears its own enable bit. In continuous mode it wraps to entry 0 and keeps going. Whenever the enable bit is armed by a write that takes it from 0 to 1, the index starts again at 0.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `ctrl_q`, `status_q`, `cap_idx` and `halt` are all zero.
- R2: A write with `reg_wr`=1 and `reg_sel`=0 loads `reg_wdata` into `ctrl_q` at the next clock. All 8 bits read back as written, including the unused bit 5. Control bits: 0 trace mode, 1 flag-halt enable, 2 capture enable, 3 continuous capture, 4 interrupt inhibit, 5 spare, 6 watch-halt enable, 7 break-halt enable.
- R3: A write with `reg_sel`=1 targets the read-only status byte and is ignored. Neither `ctrl_q` nor `status_q` changes because of it.
- R4: `halt` is high in the cycle after `brk_hit` was seen with control bit 7 set, and is never caused by `brk_hit` while bit 7 is clear.
- R5: In the same way, `wpt_hit` may raise `halt` only with control bit 6 set, and `flg_hit` only with control bit 1 set. `halt` is the OR of the three gated sources, delayed by one clock.
- R6: Status bits 7, 6 and 5 are set one clock after a gated break, watch or flag match, in that order. They stay set until a control write. A control write clears them unless a gated match arrives in the same cycle.
- R7: Status bit 4 mirrors control bit 6 and status bit 3 mirrors control bit 7. Status bit 2 shows `wpt_hit` from the previous cycle, whether or not the watch enable is set. Status bit 1 reads 0.
- R8: `cap_we` equals `cap_evt` AND control bit 2. After each capture write below the last entry, `cap_idx` increases by one.
- R9: With bit 3 clear, a capture write at entry DEPTH-1 clears control bit 2, so no further capture writes follow.
- R10: With bit 3 set, a capture write at entry DEPTH-1 returns `cap_idx` to 0, and control bit 2 stays set.
- R11: A control write that takes bit 2 from 0 to 1 sets `cap_idx` to 0.
- R12: Status bit 0 changes value once for every capture write.
- R13: `irq_inhibit` follows control bit 4 and `trace_mode` follows control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| reg_wr | input | 1 | Register write strobe from the monitor |
| reg_sel | input | 1 | 0 selects the control register, 1 the read-only status byte |
| reg_wdata | input | 8 | Write data |
| brk_hit | input | 1 | Raw breakpoint address match |
| wpt_hit | input | 1 | Raw watchpoint match |
| flg_hit | input | 1 | Raw flag match |
| cap_evt | input | 1 | One trace entry is ready for capture |
| halt | output | 1 | Registered halt request to the target CPU |
| irq_inhibit | output | 1 | Interrupt inhibit level |
| trace_mode | output | 1 | Trace mode level |
| cap_we | output | 1 | History buffer write enable |
| cap_idx | output | IDX_W | History buffer entry index |
| ctrl_q | output | 8 | Control register contents |
| status_q | output | 8 | Status byte |

## Verification
The assertions assume that the match inputs and the capture event are clean, single-clock-domain levels that can be sampled at every edge. They also assume that a status write never happens in a cycle where a capture write could auto-clear the enable bit. Only under that condition do they check that `ctrl_q` holds. The random stimulus draws all of these inputs freely, one cycle at a time, from a seeded generator. The rule about status writes is checked cycle by cycle against the bench model, not by a property. Long directed runs drive one capture event per cycle, so the index reaches the last entry in both capture modes.

// File: rtl/dhc_pkg.sv
package dhc_pkg;
  localparam int REG_W = 8;
  localparam int N_SRC = 3;

  // Control register bit positions
  localparam int CB_TRACE    = 0;
  localparam int CB_FLAG_EN  = 1;
  localparam int CB_CAP_EN   = 2;
  localparam int CB_CAP_WRAP = 3;
  localparam int CB_IRQ_INH  = 4;
  localparam int CB_SPARE    = 5;
  localparam int CB_WATCH_EN = 6;
  localparam int CB_BREAK_EN = 7;

  // Halt source order inside the gate vector; status bits 5..7 follow it
  localparam int SRC_FLAG  = 0;
  localparam int SRC_WATCH = 1;
  localparam int SRC_BREAK = 2;

  typedef logic [REG_W-1:0] reg_t;

  typedef struct packed {
    logic [N_SRC-1:0] cause;    // [2]=break [1]=watch [0]=flag
    logic             watch_en;
    logic             break_en;
    logic             watch_raw;
    logic             zero;
    logic             toggle;
  } status_t;
endpackage

// File: rtl/dhc_ctrl_reg.sv
module dhc_ctrl_reg
  import dhc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  reg_t wr_data,
  input  logic cap_done,
  output reg_t ctrl_q,
  output logic arm
);
  reg_t ctrl_d;
  logic ctrl_ce;

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_ce = 1'b0;
    if (wr_en) begin
      ctrl_d  = wr_data;
      ctrl_ce = 1'b1;
    end else if (cap_done) begin
      ctrl_d[CB_CAP_EN] = 1'b0;
      ctrl_ce = 1'b1;
    end
  end

  assign arm = wr_en && wr_data[CB_CAP_EN] && !ctrl_q[CB_CAP_EN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q == $past(wr_data)); // R2
endmodule

// File: rtl/dhc_halt_gate.sv
module dhc_halt_gate #(
  parameter int NS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] hit,
  input  logic [NS-1:0] en,
  input  logic          clr,
  output logic          halt,
  output logic [NS-1:0] cause
);
  logic [NS-1:0] gated;
  logic [NS-1:0] cause_d;
  logic          halt_d;

  for (genvar s = 0; s < NS; s++) begin : g_src
    assign gated[s]   = hit[s] & en[s];
    assign cause_d[s] = (clr ? 1'b0 : cause[s]) | gated[s];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause[s] <= 1'b0;
      else        cause[s] <= cause_d[s];
    end

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cause[s] && !clr) |=> cause[s]); // R6
    AST_CAUSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[s] && (clr || !cause[s])) |=> !cause[s]); // R6
  end

  assign halt_d = |gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt <= 1'b0;
    else        halt <= halt_d;
  end
endmodule

// File: rtl/dhc_capture.sv
module dhc_capture #(
  parameter int DEPTH = 1024,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             cap_en,
  input  logic             wrap_en,
  input  logic             evt,
  output logic             we,
  output logic [IDX_W-1:0] idx,
  output logic             done,
  output logic             toggle
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_d;
  logic             idx_ce;
  logic             at_last;

  assign we      = cap_en & evt;
  assign at_last = (idx == LAST);
  assign done    = we & at_last & !wrap_en;

  always_comb begin
    idx_d  = idx;
    idx_ce = 1'b0;
    if (arm) begin
      idx_d  = '0;
      idx_ce = 1'b1;
    end else if (we) begin
      idx_ce = 1'b1;
      if (!at_last)     idx_d = idx + IDX_W'(1);
      else if (wrap_en) idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (idx_ce) idx <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  toggle <= 1'b0;
    else if (we) toggle <= !toggle;
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !at_last) |=> idx == $past(idx) + IDX_W'(1)); // R8
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && at_last && wrap_en) |=> idx == '0); // R10
  AST_IDX_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> idx == '0); // R11
  AST_TOGGLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle != $past(toggle)) |-> $past(we)); // R12
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dhc_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  input  logic             brk_hit,
  input  logic             wpt_hit,
  input  logic             flg_hit,
  input  logic             cap_evt,
  output logic             halt,
  output logic             irq_inhibit,
  output logic             trace_mode,
  output logic             cap_we,
  output logic [IDX_W-1:0] cap_idx,
  output logic [7:0]       ctrl_q,
  output logic [7:0]       status_q
);
  logic             ctl_wr;
  logic             arm;
  logic             cap_done;
  logic             tog;
  logic             wraw_q;
  logic [N_SRC-1:0] hits;
  logic [N_SRC-1:0] ens;
  logic [N_SRC-1:0] cause;
  reg_t             ctrl;
  status_t          st;

  // Writes addressed to the status byte fall away here
  assign ctl_wr = reg_wr & !reg_sel;

  dhc_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_wr),
    .wr_data  (reg_wdata),
    .cap_done (cap_done),
    .ctrl_q   (ctrl),
    .arm      (arm)
  );

  assign hits[SRC_FLAG]  = flg_hit;
  assign hits[SRC_WATCH] = wpt_hit;
  assign hits[SRC_BREAK] = brk_hit;
  assign ens[SRC_FLAG]   = ctrl[CB_FLAG_EN];
  assign ens[SRC_WATCH]  = ctrl[CB_WATCH_EN];
  assign ens[SRC_BREAK]  = ctrl[CB_BREAK_EN];

  dhc_halt_gate #(.NS(N_SRC)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hits),
    .en    (ens),
    .clr   (ctl_wr),
    .halt  (halt),
    .cause (cause)
  );

  dhc_capture #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .cap_en  (ctrl[CB_CAP_EN]),
    .wrap_en (ctrl[CB_CAP_WRAP]),
    .evt     (cap_evt),
    .we      (cap_we),
    .idx     (cap_idx),
    .done    (cap_done),
    .toggle  (tog)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wraw_q <= 1'b0;
    else        wraw_q <= wpt_hit;
  end

  always_comb begin
    st.cause     = cause;
    st.watch_en  = ctrl[CB_WATCH_EN];
    st.break_en  = ctrl[CB_BREAK_EN];
    st.watch_raw = wraw_q;
    st.zero      = 1'b0;
    st.toggle    = tog;
  end

  assign status_q    = st;
  assign ctrl_q      = ctrl;
  assign irq_inhibit = ctrl[CB_IRQ_INH];
  assign trace_mode  = ctrl[CB_TRACE];

  AST_BREAK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_hit && !ctrl_q[CB_BREAK_EN] && !wpt_hit && !flg_hit) |=> !halt); // R4
  AST_HALT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> $past((brk_hit && ctrl_q[CB_BREAK_EN]) || (wpt_hit && ctrl_q[CB_WATCH_EN])
                   || (flg_hit && ctrl_q[CB_FLAG_EN]))); // R5
  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && !cap_we) |=> ctrl_q == $past(ctrl_q)); // R3
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_we && cap_idx == IDX_W'(DEPTH - 1) && !ctrl_q[CB_CAP_WRAP] && !ctl_wr)
      |=> !ctrl_q[CB_CAP_EN]); // R9
  AST_WATCH_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    wpt_hit |=> status_q[2]); // R7
endmodule

// File: tb/sim_dbg_halt_ctrl.sv
module sim_dbg_halt_ctrl;
  localparam int DEPTH = 1024;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic brk_hit = 1'b0, wpt_hit = 1'b0, flg_hit = 1'b0, cap_evt = 1'b0;
  logic halt, irq_inhibit, trace_mode, cap_we;
  logic [IW-1:0] cap_idx;
  logic [7:0] ctrl_q, status_q;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model state
  logic [7:0]    m_ctrl;
  logic [2:0]    m_cause;
  logic          m_halt, m_tog, m_wraw;
  logic [IW-1:0] m_idx;

  always #5 clk = ~clk;

  dbg_halt_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .brk_hit(brk_hit), .wpt_hit(wpt_hit), .flg_hit(flg_hit), .cap_evt(cap_evt),
    .halt(halt), .irq_inhibit(irq_inhibit), .trace_mode(trace_mode), .cap_we(cap_we),
    .cap_idx(cap_idx), .ctrl_q(ctrl_q), .status_q(status_q)
  );

  function automatic logic [7:0] exp_status();
    return {m_cause[2], m_cause[1], m_cause[0], m_ctrl[6], m_ctrl[7], m_wraw, 1'b0, m_tog};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_cause = '0; m_halt = 1'b0; m_tog = 1'b0; m_wraw = 1'b0; m_idx = '0;
    end else begin
      logic wc, cev, last;
      logic [2:0] g;
      wc   = reg_wr && !reg_sel;
      cev  = cap_evt && m_ctrl[2];
      last = (m_idx == IW'(DEPTH - 1));
      g    = {brk_hit & m_ctrl[7], wpt_hit & m_ctrl[6], flg_hit & m_ctrl[1]};
      m_halt  = |g;
      m_cause = (wc ? 3'b000 : m_cause) | g;
      m_wraw  = wpt_hit;
      if (cev) m_tog = !m_tog;
      if (wc && reg_wdata[2] && !m_ctrl[2]) m_idx = '0;
      else if (cev) begin
        if (!last)         m_idx = m_idx + IW'(1);
        else if (m_ctrl[3]) m_idx = '0;
      end
      if (wc) m_ctrl = reg_wdata;
      else if (cev && last && !m_ctrl[3]) m_ctrl[2] = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic check_all();
    chk("R2 ctrl_q", 32'(ctrl_q), 32'(m_ctrl));
    chk("R4 R5 halt", 32'(halt), 32'(m_halt));
    chk("R6 cause bits", 32'(status_q[7:5]), 32'(exp_status() >> 5));
    chk("R7 status mirror", 32'(status_q[4:1]), 32'(exp_status()[4:1]));
    chk("R12 toggle", 32'(status_q[0]), 32'(m_tog));
    chk("R8 cap_we", 32'(cap_we), 32'(m_ctrl[2] & cap_evt));
    chk("R8 cap_idx", 32'(cap_idx), 32'(m_idx));
    chk("R13 outputs", 32'({irq_inhibit, trace_mode}), 32'({m_ctrl[4], m_ctrl[0]}));
  endtask

  // one clock: check the state left by the last edge, then drive the next inputs
  task automatic cyc(input logic wr, input logic sel, input logic [7:0] d,
                     input logic b, input logic w, input logic f, input logic e);
    @(negedge clk);
    check_all();
    reg_wr = wr; reg_sel = sel; reg_wdata = d;
    brk_hit = b; wpt_hit = w; flg_hit = f; cap_evt = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap_c, snap_s;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state while held and after release
    chk("R1 ctrl", 32'(ctrl_q), 0);
    chk("R1 status", 32'(status_q), 0);
    chk("R1 halt", 32'(halt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idx", 32'(cap_idx), 0);
    chk("R1 status after release", 32'(status_q), 0);

    // R2 every bit, including the spare bit 5
    cyc(1'b1, 1'b0, 8'h20, 0, 0, 0, 0);
    cyc(1'b0, 1'b0, 8'h00, 0, 0, 0, 0);
    chk("R2 spare bit readback", 32'(ctrl_q), 32'h20);

    // R4: break blocked, then allowed
    cyc(1'b1, 1'b0, 8'h00, 0, 0, 0, 0);
    cyc(1'b0, 1'b0, 8'h00, 1, 0, 0, 0);
    cyc(1'b0, 1'b0, 8'h00, 0, 0, 0, 0);
    chk("R4 break gated off", 32'(halt), 0);
    cyc(1'b1, 1'b0, 8'h80, 0, 0, 0, 0);
    cyc(1'b0, 1'b0, 8'h00, 1, 0, 0, 0);
    cyc(1'b0, 1'b0, 8'h00, 0, 0, 0, 0);
    chk("R4 break halts", 32'(halt), 1);
    chk("R6 break cause set", 32'(status_q[7]), 1);
    idle(3);
    chk("R6 break cause sticky", 32'(status_q[7]), 1);

    // R5 and R7: watch raw visible with enable clear; flag gated by bit 1
    cyc(1'b1, 1'b0, 8'h02, 0, 0, 0, 0);
    cyc(1'b0, 1'b0, 8'h00, 0, 1, 0, 0);
    cyc(1'b0, 1'b0, 8'h00, 0, 0, 1, 0);
    chk("R7 raw watch without halt", 32'(status_q[2]), 1);
    chk("R5 watch gated off", 32'(halt), 0);
    chk("R6 cleared by ctrl write", 32'(status_q[7]), 0);
    cyc(1'b0, 1'b0, 8'h00, 0, 0, 0, 0);
    chk("R5 flag halts", 32'(halt), 1);
    chk("R6 flag cause", 32'(status_q[5]), 1);

    // R3 status write ignored
    snap_c = ctrl_q; snap_s = status_q;
    cyc(1'b1, 1'b1, 8'hFF, 0, 0, 0, 0);
    cyc(1'b0, 1'b0, 8'h00, 0, 0, 0, 0);
    chk("R3 ctrl unchanged", 32'(ctrl_q), 32'(snap_c));
    chk("R3 status unchanged", 32'(status_q), 32'(snap_s));

    // R9 one-shot: fill every entry, then more events
    cyc(1'b1, 1'b0, 8'h04, 0, 0, 0, 0);
    for (int i = 0; i < DEPTH + 8; i++) cyc(1'b0, 1'b0, 8'h00, 0, 0, 0, 1);
    cyc(1'b0, 1'b0, 8'h00, 0, 0, 0, 0);
    chk("R9 enable self-cleared", 32'(ctrl_q[2]), 0);
    chk("R9 index held at last", 32'(cap_idx), DEPTH - 1);

    // R11 re-arm resets index
    cyc(1'b1, 1'b0, 8'h0C, 0, 0, 0, 0);
    cyc(1'b0, 1'b0, 8'h00, 0, 0, 0, 0);
    chk("R11 index rearmed", 32'(cap_idx), 0);

    // R10 continuous wrap
    for (int i = 0; i < DEPTH; i++) cyc(1'b0, 1'b0, 8'h00, 0, 0, 0, 1);
    cyc(1'b0, 1'b0, 8'h00, 0, 0, 0, 0);
    chk("R10 index wrapped", 32'(cap_idx), 0);
    chk("R10 enable kept", 32'(ctrl_q[2]), 1);

    // random mix, compared against the model every cycle
    for (int i = 0; i < 6000; i++) begin
      logic wr;
      wr = ($urandom % 16) == 0;
      cyc(wr, 1'($urandom), 8'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
          ($urandom % 4) == 0, 1'($urandom));
    end
    idle(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule